// File: doc/BRIEF.md
# Multi-Stream Synchronous Start Gate

This block decides, frame by frame, which of a controller's DMA streams may move data on a serial link. The design serves four input streams and four output streams. Software writes an 8-bit hold mask through a 32-bit register. A set hold bit keeps its stream off the link, even while that stream's engine is running. A clear hold bit lets the stream transfer once its run bit and its FIFO-ready flag are both high.

Changes to the mask do not reach the streams at once. The block copies the register into a frame-aligned hold vector, and it does so only on the link's frame-start pulse. As a result, every stream released or held by one register write changes state at the same frame boundary. This is how a group of engines is started together: set their hold bits, start the engines, wait for their FIFOs, then clear the hold bits with one write. A group is stopped the same way: set the hold bits first, then clear the run bits. A stream whose hold bit stays clear simply follows its own run and ready inputs.

Top module: `sync_start_gate`

## Requirements
- R1: After reset, the register reads 0x00000000 and the frame-aligned hold vector is all zero. A running stream with its FIFO ready is therefore enabled before any frame pulse arrives.
- R2: A write with `reg_wr_en` high at address 0x34 stores `reg_wdata[7:0]`, and the new value is visible from the next cycle. A read at 0x34 returns the stored mask in bits 7:0. Bits 31:8 always read zero, and any value written to them is discarded.
- R3: A write to any address other than 0x34 leaves the mask unchanged. A read at any other address returns zero.
- R4: Mask bit k, for k from 0 to 3, controls input stream k+1 on `link_en[k]`. Mask bit 4+j, for j from 0 to 3, controls output stream j+1 on `link_en[4+j]`. Bit k of `run`, `fifo_rdy` and `link_en` all refer to the same stream.
- R5: The hold vector takes the register's value only at a clock edge where `frame_start` is high. A register write in the same cycle as a frame pulse therefore takes effect at the following frame pulse.
- R6: `link_en[k]` is high exactly when `run[k]` is 1, `fifo_rdy[k]` is 1 and hold bit k is 0. The output is combinational in these inputs and the hold vector.
- R7: Streams whose hold bits are cleared by one write all raise `link_en` in the same cycle, the cycle after the next frame pulse.
- R8: Setting hold bits blocks those streams from the next frame onward, whatever their run and ready inputs are.
- R9: A stream whose hold bit is 0 follows its run and ready inputs in the same cycle, with no wait for a frame pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Single-cycle write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| run | input | 8 | Per-stream engine run bits |
| fifo_rdy | input | 8 | Per-stream FIFO-ready flags |
| frame_start | input | 1 | One-cycle pulse at each link frame start |
| link_en | output | 8 | Per-stream link enable |

## Verification
The bench builds the block with its default parameters: four input streams, four output streams, an 8-bit address and the register at 0x34. With these values both halves of the bit mapping can be tested, including the boundary between input stream 4 and output stream 1. The decode can also be probed at the neighbouring offsets 0x30 and 0x38. A behavioural model tracks the register and the frame-aligned hold vector, and it is compared on every cycle. Directed sequences cover group start, group stop, a write that coincides with a frame pulse, and streams that run unmasked.

// File: rtl/sync_gate_pkg.sv
package sync_gate_pkg;
    localparam int SG_IN_STREAMS  = 4;
    localparam int SG_OUT_STREAMS = 4;
    localparam int SG_ADDR_W      = 8;
    localparam int SG_DATA_W      = 32;
    localparam int SG_REG_OFFSET  = 'h34;
endpackage

// File: rtl/sg_mask_reg.sv
module sg_mask_reg #(
    parameter int NS      = 8,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int OFFSET  = 'h34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NS-1:0]     mask_o
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(OFFSET);

    typedef struct packed {
        logic [NS-1:0] mask;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       hit;
    logic       unused_wdata_hi;

    assign hit             = (addr == HIT_ADDR);
    assign unused_wdata_hi = ^wdata[DATA_W-1:NS];

    always_comb begin
        st_d = st_q;
        if (wr_en && hit) begin
            st_d.mask = wdata[NS-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[NS-1:0] = st_q.mask;
        end
    end

    assign mask_o = st_q.mask;
endmodule

// File: rtl/sg_frame_latch.sv
module sg_frame_latch #(
    parameter int NS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic [NS-1:0] mask_i,
    output logic [NS-1:0] hold_o
);
    typedef struct packed {
        logic [NS-1:0] hold;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d.hold = mask_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = st_q.hold;
endmodule

// File: rtl/sg_stream_gate.sv
module sg_stream_gate #(
    parameter int NUM_IN  = 4,
    parameter int NUM_OUT = 4,
    localparam int NS     = NUM_IN + NUM_OUT
) (
    input  logic [NS-1:0] run,
    input  logic [NS-1:0] fifo_rdy,
    input  logic [NS-1:0] hold,
    output logic [NS-1:0] link_en
);
    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
        assign link_en[gi] = run[gi] & fifo_rdy[gi] & ~hold[gi];
    end

    for (genvar go = 0; go < NUM_OUT; go++) begin : g_out
        localparam int IDX = NUM_IN + go;
        assign link_en[IDX] = run[IDX] & fifo_rdy[IDX] & ~hold[IDX];
    end
endmodule

// File: rtl/sync_start_gate.sv
module sync_start_gate
    import sync_gate_pkg::*;
#(
    parameter int NUM_IN     = SG_IN_STREAMS,
    parameter int NUM_OUT    = SG_OUT_STREAMS,
    parameter int ADDR_W     = SG_ADDR_W,
    parameter int DATA_W     = SG_DATA_W,
    parameter int REG_OFFSET = SG_REG_OFFSET,
    localparam int NS        = NUM_IN + NUM_OUT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NS-1:0]     run,
    input  logic [NS-1:0]     fifo_rdy,
    input  logic              frame_start,
    output logic [NS-1:0]     link_en
);
    logic [NS-1:0] mask_w;
    logic [NS-1:0] hold_w;

    sg_mask_reg #(
        .NS(NS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(REG_OFFSET)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .mask_o(mask_w)
    );

    sg_frame_latch #(.NS(NS)) u_latch (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .mask_i(mask_w), .hold_o(hold_w)
    );

    sg_stream_gate #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_gate (
        .run(run), .fifo_rdy(fifo_rdy), .hold(hold_w), .link_en(link_en)
    );
endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
    parameter int NS         = 8,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int REG_OFFSET = 'h34
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              frame_start,
    input logic [NS-1:0]     mask_w,
    input logic [NS-1:0]     hold_w,
    input logic [NS-1:0]     link_en
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);

    AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == HIT_ADDR) |=> (mask_w == $past(reg_wdata[NS-1:0]))); // R2

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[DATA_W-1:NS] == '0)); // R2

    AST_OTHER_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_addr == HIT_ADDR) |=> $stable(mask_w)); // R3

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(hold_w)); // R5

    AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (hold_w == $past(mask_w))); // R5

    AST_HELD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((hold_w & link_en) == '0)); // R8
endmodule

bind sync_start_gate sg_checker #(
    .NS(NS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET)
) u_sg_checker (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .mask_w(mask_w), .hold_w(hold_w), .link_en(link_en)
);

// File: tb/test_sync_start_gate.sv
`timescale 1ns/1ps
module test_sync_start_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h34;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  run = '0;
    logic [7:0]  fifo_rdy = '0;
    logic        frame_start = 1'b0;
    logic [7:0]  link_en;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Behavioural reference state
    logic [7:0] m_mask = '0;
    logic [7:0] m_hold = '0;

    always #2.5 clk = ~clk;

    sync_start_gate i_sync_start_gate (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .run(run),
        .fifo_rdy(fifo_rdy), .frame_start(frame_start), .link_en(link_en)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask <= '0;
            m_hold <= '0;
        end else begin
            if (frame_start) m_hold <= m_mask;
            if (reg_wr_en && reg_addr == 8'h34) m_mask <= reg_wdata[7:0];
        end
    end

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model (R6 enables, R2/R3 read data)
    always @(negedge clk) begin
        if (rst_n) begin
            check_eq("R6 link_en vs model", {24'h0, link_en}, {24'h0, run & fifo_rdy & ~m_hold});
            check_eq("R2 R3 rdata vs model", reg_rdata,
                     (reg_addr == 8'h34) ? {24'h0, m_mask} : 32'h0);
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        step(); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        step(); reg_wr_en = 1'b0; reg_addr = 8'h34;
    endtask

    task automatic frame();
        step(); frame_start = 1'b1;
        step(); frame_start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        run = 8'hFF; fifo_rdy = 8'hFF;
        @(negedge clk);
        check_eq("R1 reset read", reg_rdata, 32'h0);
        check_eq("R1 enabled without frame", {24'h0, link_en}, 32'hFF);

        reg_write(8'h34, 32'hFFFF_FFA5);
        @(negedge clk);
        check_eq("R2 read back mask", reg_rdata, 32'h0000_00A5);
        check_eq("R5 no effect before frame", {24'h0, link_en}, 32'hFF);
        step(); reg_addr = 8'h30;
        @(negedge clk);
        check_eq("R3 other address reads zero", reg_rdata, 32'h0);
        step(); reg_addr = 8'h34;
        reg_write(8'h38, 32'h0000_00FF);
        @(negedge clk);
        check_eq("R3 foreign write ignored", reg_rdata, 32'h0000_00A5);

        frame();
        @(negedge clk);
        check_eq("R6 gated by hold", {24'h0, link_en}, 32'h5A);

        // write coincident with frame pulse
        step(); reg_wr_en = 1'b1; reg_wdata = 32'h0; frame_start = 1'b1;
        step(); reg_wr_en = 1'b0; frame_start = 1'b0;
        @(negedge clk);
        check_eq("R5 coincident write deferred", {24'h0, link_en}, 32'h5A);
        frame();
        @(negedge clk);
        check_eq("R5 applied on following frame", {24'h0, link_en}, 32'hFF);

        // bit mapping
        reg_write(8'h34, 32'h01); frame();
        @(negedge clk);
        check_eq("R4 bit0 is input stream 1", {24'h0, link_en}, 32'hFE);
        reg_write(8'h34, 32'h08); frame();
        @(negedge clk);
        check_eq("R4 bit3 is input stream 4", {24'h0, link_en}, 32'hF7);
        reg_write(8'h34, 32'h10); frame();
        @(negedge clk);
        check_eq("R4 bit4 is output stream 1", {24'h0, link_en}, 32'hEF);

        // synchronous group start
        reg_write(8'h34, 32'hF0); frame();
        step(); fifo_rdy = 8'h0F;
        @(negedge clk);
        check_eq("R7 held group idle", {24'h0, link_en}, 32'h0F);
        step(); fifo_rdy = 8'hFF;
        @(negedge clk);
        check_eq("R7 ready but still held", {24'h0, link_en}, 32'h0F);
        reg_write(8'h34, 32'h00);
        @(negedge clk);
        check_eq("R7 release waits for frame", {24'h0, link_en}, 32'h0F);
        frame();
        @(negedge clk);
        check_eq("R7 group released together", {24'h0, link_en}, 32'hFF);

        // synchronous stop
        reg_write(8'h34, 32'hFF); frame();
        @(negedge clk);
        check_eq("R8 all held", {24'h0, link_en}, 32'h00);
        step(); run = 8'h00;
        @(negedge clk);
        check_eq("R8 stopped", {24'h0, link_en}, 32'h00);

        // unmasked stream follows run
        reg_write(8'h34, 32'h00); frame();
        step(); run = 8'h04;
        @(negedge clk);
        check_eq("R9 runs immediately", {24'h0, link_en}, 32'h04);
        step(); fifo_rdy = 8'hFB;
        @(negedge clk);
        check_eq("R6 not ready blocks", {24'h0, link_en}, 32'h00);

        repeat (4) step();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule